// File: doc/BRIEF.md
# Message Interrupt to Indicator Converter

This block sits at the end of a message-signalled interrupt path. A device posts a 32-bit message word, and the block splits it into a function identifier and a vector number. It looks the function up in a small table that is loaded through a configuration port. For a known function it sets one bit in an in-memory indicator bitmap and one bit in a summary bitmap. It also raises an adapter interrupt, but only when the summary byte was clear before the update.

Each bit is set by an atomic read-modify-write of a single byte over a byte-wide memory port. A lock output stays high from the read through the write-back. The indicator byte is always finished before the summary byte is read. A message for an unknown function, or a memory fault on either read, produces an error event instead of an interrupt. Only one message is handled at a time, and the message input is not ready while a message is in flight. Reads of the message window return all ones.

Top module: `msi_bitmap_setter`

## Requirements
- R1: A message word splits as follows. The vector is bits [10:0] of `msg_wdata`. The function identifier is `msg_wdata` shifted right by 11, so it spans bits [31:11].
- R2: For a known function, let N = indicator offset + vector. The block sets bit N of the indicator bitmap. The byte address is indicator base + N/8. Bits are numbered MSB-first within a byte, so the mask is 8'h80 >> (N mod 8).
- R3: The summary bit is placed the same way, with N = summary offset. The vector takes no part in it. The byte address is summary base + N/8 and the mask is 8'h80 >> (N mod 8).
- R4: Each byte update is a read followed by a write to the same address. The written value is the old byte ORed with the mask, so every other bit keeps its value. `mem_lock` is high on both the read and the write.
- R5: For one message the memory sees exactly four operations, in this order: indicator read, indicator write, summary read, summary write.
- R6: `irq_valid` pulses only when the old summary byte was 8'h00. It is then high for one cycle. `irq_word` is bit 31 set, ORed with the function's 3-bit interrupt subclass shifted left by 27.
- R7: If no valid table entry matches the identifier, the block pulses `err_valid` with `err_code` 8'h10. `err_fid` carries the identifier and `err_qual` carries the vector shifted left by 16. No memory operation is issued.
- R8: If the memory answers a read with `mem_err`, the block pulses `err_valid` with `err_code` 8'h13 and both `err_fid` and `err_qual` zero. It then issues no further memory operation for that message and raises no interrupt.
- R9: The block handles one message at a time, and `msg_ready` is low while it is busy. With a one-cycle read latency, `msg_ready` stays low for this many cycles after the accepting edge: 7 for a completed message, 1 for an unknown identifier, 3 for an indicator fault and 6 for a summary fault.
- R10: A read of the message window (`msg_rd_en`) is answered on the next cycle with `msg_rd_valid` high and `msg_rd_data` 32'hFFFF_FFFF.
- R11: A table slot is written when `cfg_we` is high. If two valid slots hold the same identifier, the lower slot index wins. A slot written with `cfg_valid` low no longer matches.
- R12: After reset `msg_ready` is high, no memory request, interrupt or error is active, and every table slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message write present |
| msg_ready | output | 1 | Block can accept a message |
| msg_wdata | input | 32 | Message word (function identifier and vector) |
| msg_rd_en | input | 1 | Read of the message window |
| msg_rd_valid | output | 1 | Window read answer valid |
| msg_rd_data | output | 32 | Window read data |
| cfg_we | input | 1 | Table slot write strobe |
| cfg_idx | input | IDX_W | Table slot index |
| cfg_valid | input | 1 | Slot valid flag to write |
| cfg_fid | input | 21 | Slot function identifier |
| cfg_ind_base | input | 32 | Indicator bitmap base byte address |
| cfg_ind_off | input | 16 | Indicator bit offset |
| cfg_sum_base | input | 32 | Summary bitmap base byte address |
| cfg_sum_off | input | 16 | Summary bit offset |
| cfg_isc | input | 3 | Interrupt subclass |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Atomic sequence in progress |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rvalid | input | 1 | Read answer valid |
| mem_rdata | input | 8 | Read byte |
| mem_err | input | 1 | Read answer is a fault |
| irq_valid | output | 1 | Adapter interrupt pulse |
| irq_word | output | 32 | Interrupt word |
| err_valid | output | 1 | Error event pulse |
| err_code | output | 8 | Error code |
| err_fid | output | 21 | Error function identifier |
| err_qual | output | 32 | Error qualifier |

## Verification
The bench's memory model answers each read one cycle after the request. For each message, the bench counts the cycles from the accepting edge until `msg_ready` returns. The expected counts are 7, 1, 3 or 6, depending on whether the message completes, misses the table, or faults on the indicator or summary read. The bench samples `irq_valid` and `err_valid` on every falling edge inside that window, including the first falling edge on which `msg_ready` is high again. The error pulse of a miss or a fault falls on that cycle, and the interrupt falls in the last busy cycle. The memory model logs each operation's kind, address and lock level as it happens. Memory contents are compared only after the message has finished.

// File: rtl/msib_pkg.sv
package msib_pkg;

    parameter int DATA_W = 32;
    parameter int VEC_W  = 11;
    parameter int FID_W  = DATA_W - VEC_W;
    parameter int AW     = 32;
    parameter int OFF_W  = 16;
    parameter int ISC_W  = 3;
    parameter int QUAL_W = 32;
    parameter int QUAL_SH = 16;
    parameter int IRQ_W  = 32;
    parameter int ISC_SH = 27;

    localparam int BN_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1;

    localparam logic [7:0] ERR_NO_FN     = 8'h10;
    localparam logic [7:0] ERR_MEM_FAULT = 8'h13;
    localparam logic [IRQ_W-1:0] IRQ_ADAPTER_FLAG = {1'b1, {(IRQ_W-1){1'b0}}};

    typedef struct packed {
        logic [AW-1:0]    ind_base;
        logic [OFF_W-1:0] ind_off;
        logic [AW-1:0]    sum_base;
        logic [OFF_W-1:0] sum_off;
        logic [ISC_W-1:0] isc;
    } fn_map_t;

    typedef struct packed {
        logic             vld;
        logic [FID_W-1:0] fid;
        fn_map_t          map;
    } fn_entry_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [7:0]    mask;
    } bit_loc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOKUP, ST_IND_RD, ST_IND_WAIT,
        ST_IND_WR, ST_SUM_RD, ST_SUM_WAIT, ST_SUM_WR
    } seq_st_t;

    function automatic bit_loc_t locate(input logic [AW-1:0] base,
                                        input logic [OFF_W-1:0] off,
                                        input logic [VEC_W-1:0] vec);
        logic [BN_W-1:0] bn;
        bit_loc_t r;
        bn     = BN_W'(off) + BN_W'(vec);
        r.addr = base + AW'(bn >> 3);
        r.mask = 8'h80 >> bn[2:0];
        return r;
    endfunction

    function automatic logic [IRQ_W-1:0] make_irq_word(input logic [ISC_W-1:0] isc);
        return (IRQ_W'(isc) << ISC_SH) | IRQ_ADAPTER_FLAG;
    endfunction

endpackage

// File: rtl/msib_fn_table.sv
module msib_fn_table
    import msib_pkg::*;
#(
    parameter int NUM_FN = 8,
    localparam int IDX_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  fn_entry_t        cfg_entry,
    input  logic [FID_W-1:0] look_fid,
    output logic             hit,
    output fn_map_t          hit_map
);

    fn_entry_t         slot_q [NUM_FN];
    logic [NUM_FN-1:0] match;

    for (genvar g = 0; g < NUM_FN; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
                slot_q[g] <= cfg_entry;
            end
        end
        assign match[g] = slot_q[g].vld && (slot_q[g].fid == look_fid);
    end

    // lowest matching slot wins
    always_comb begin
        hit     = 1'b0;
        hit_map = '0;
        for (int i = NUM_FN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_map = slot_q[i].map;
            end
        end
    end

    AST_HIT_MEANS_MATCH: assert property (@(posedge clk) disable iff (rst)
        hit |-> (match != '0)) else $error("hit without match"); // R11

endmodule

// File: rtl/msib_locator.sv
module msib_locator
    import msib_pkg::*;
(
    input  logic [AW-1:0]    base,
    input  logic [OFF_W-1:0] off,
    input  logic [VEC_W-1:0] vec,
    output bit_loc_t         loc
);

    assign loc = locate(base, off, vec);

endmodule

// File: rtl/msib_seq.sv
module msib_seq
    import msib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [DATA_W-1:0] msg_wdata,
    output logic [FID_W-1:0]  look_fid,
    input  logic              hit,
    input  fn_map_t           hit_map,
    output fn_map_t           map_q,
    output logic [VEC_W-1:0]  vec_q,
    input  bit_loc_t          ind_loc,
    input  bit_loc_t          sum_loc,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_err,
    output logic              irq_valid,
    output logic [IRQ_W-1:0]  irq_word,
    output logic              err_valid,
    output logic [7:0]        err_code,
    output logic [FID_W-1:0]  err_fid,
    output logic [QUAL_W-1:0] err_qual
);

    seq_st_t          st_q;
    logic [FID_W-1:0] fid_q;
    logic [7:0]       old_q;
    logic             on_ind;

    assign msg_ready = (st_q == ST_IDLE);
    assign look_fid  = fid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            fid_q     <= '0;
            vec_q     <= '0;
            map_q     <= '0;
            old_q     <= '0;
            irq_valid <= 1'b0;
            irq_word  <= '0;
            err_valid <= 1'b0;
            err_code  <= '0;
            err_fid   <= '0;
            err_qual  <= '0;
        end else begin
            irq_valid <= 1'b0;
            err_valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (msg_valid) begin
                        vec_q <= msg_wdata[VEC_W-1:0];
                        fid_q <= msg_wdata[DATA_W-1:VEC_W];
                        st_q  <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        map_q <= hit_map;
                        st_q  <= ST_IND_RD;
                    end else begin
                        err_valid <= 1'b1;
                        err_code  <= ERR_NO_FN;
                        err_fid   <= fid_q;
                        err_qual  <= QUAL_W'(vec_q) << QUAL_SH;
                        st_q      <= ST_IDLE;
                    end
                end
                ST_IND_RD: st_q <= ST_IND_WAIT;
                ST_IND_WAIT: begin
                    if (mem_rvalid) begin
                        if (mem_err) begin
                            err_valid <= 1'b1;
                            err_code  <= ERR_MEM_FAULT;
                            err_fid   <= '0;
                            err_qual  <= '0;
                            st_q      <= ST_IDLE;
                        end else begin
                            old_q <= mem_rdata;
                            st_q  <= ST_IND_WR;
                        end
                    end
                end
                ST_IND_WR: st_q <= ST_SUM_RD;
                ST_SUM_RD: st_q <= ST_SUM_WAIT;
                ST_SUM_WAIT: begin
                    if (mem_rvalid) begin
                        if (mem_err) begin
                            err_valid <= 1'b1;
                            err_code  <= ERR_MEM_FAULT;
                            err_fid   <= '0;
                            err_qual  <= '0;
                            st_q      <= ST_IDLE;
                        end else begin
                            old_q <= mem_rdata;
                            st_q  <= ST_SUM_WR;
                            if (mem_rdata == 8'h00) begin
                                irq_valid <= 1'b1;
                                irq_word  <= make_irq_word(map_q.isc);
                            end
                        end
                    end
                end
                ST_SUM_WR: st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        on_ind    = (st_q == ST_IND_RD) || (st_q == ST_IND_WAIT) || (st_q == ST_IND_WR);
        mem_req   = (st_q == ST_IND_RD) || (st_q == ST_IND_WR) ||
                    (st_q == ST_SUM_RD) || (st_q == ST_SUM_WR);
        mem_we    = (st_q == ST_IND_WR) || (st_q == ST_SUM_WR);
        mem_lock  = on_ind || (st_q == ST_SUM_RD) || (st_q == ST_SUM_WAIT) ||
                    (st_q == ST_SUM_WR);
        mem_addr  = on_ind ? ind_loc.addr : sum_loc.addr;
        mem_wdata = old_q | (on_ind ? ind_loc.mask : sum_loc.mask);
    end

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> !msg_ready) else $error("second accept"); // R9

    AST_WRITE_IS_OR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ($past(mem_rvalid) &&
            ((mem_wdata & $past(mem_rdata)) == $past(mem_rdata)) &&
            ($countones(mem_wdata ^ $past(mem_rdata)) <= 1)))
        else $error("write not an OR of the read byte"); // R4

    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_lock && $past(mem_lock)))
        else $error("write outside lock"); // R4

    AST_IRQ_WITH_SUM_WRITE: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (mem_req && mem_we && !err_valid))
        else $error("interrupt outside summary write"); // R6

    AST_ERR_QUIET_MEM: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (!mem_req && !irq_valid && msg_ready))
        else $error("memory active during error"); // R8

endmodule

// File: rtl/msi_bitmap_setter.sv
module msi_bitmap_setter
    import msib_pkg::*;
#(
    parameter int NUM_FN = 8,
    localparam int IDX_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [DATA_W-1:0] msg_wdata,
    input  logic              msg_rd_en,
    output logic              msg_rd_valid,
    output logic [DATA_W-1:0] msg_rd_data,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [FID_W-1:0]  cfg_fid,
    input  logic [AW-1:0]     cfg_ind_base,
    input  logic [OFF_W-1:0]  cfg_ind_off,
    input  logic [AW-1:0]     cfg_sum_base,
    input  logic [OFF_W-1:0]  cfg_sum_off,
    input  logic [ISC_W-1:0]  cfg_isc,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_err,
    output logic              irq_valid,
    output logic [IRQ_W-1:0]  irq_word,
    output logic              err_valid,
    output logic [7:0]        err_code,
    output logic [FID_W-1:0]  err_fid,
    output logic [QUAL_W-1:0] err_qual
);

    fn_entry_t        cfg_entry;
    fn_map_t          hit_map;
    fn_map_t          map_q;
    logic             hit;
    logic [FID_W-1:0] look_fid;
    logic [VEC_W-1:0] vec_q;
    bit_loc_t         ind_loc;
    bit_loc_t         sum_loc;
    logic             rd_q;

    always_comb begin
        cfg_entry.vld          = cfg_valid;
        cfg_entry.fid          = cfg_fid;
        cfg_entry.map.ind_base = cfg_ind_base;
        cfg_entry.map.ind_off  = cfg_ind_off;
        cfg_entry.map.sum_base = cfg_sum_base;
        cfg_entry.map.sum_off  = cfg_sum_off;
        cfg_entry.map.isc      = cfg_isc;
    end

    msib_fn_table #(.NUM_FN(NUM_FN)) u_table (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_entry (cfg_entry),
        .look_fid  (look_fid),
        .hit       (hit),
        .hit_map   (hit_map)
    );

    msib_locator u_ind_loc (
        .base (map_q.ind_base),
        .off  (map_q.ind_off),
        .vec  (vec_q),
        .loc  (ind_loc)
    );

    msib_locator u_sum_loc (
        .base (map_q.sum_base),
        .off  (map_q.sum_off),
        .vec  ('0),
        .loc  (sum_loc)
    );

    msib_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .msg_valid  (msg_valid),
        .msg_ready  (msg_ready),
        .msg_wdata  (msg_wdata),
        .look_fid   (look_fid),
        .hit        (hit),
        .hit_map    (hit_map),
        .map_q      (map_q),
        .vec_q      (vec_q),
        .ind_loc    (ind_loc),
        .sum_loc    (sum_loc),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_lock   (mem_lock),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_err    (mem_err),
        .irq_valid  (irq_valid),
        .irq_word   (irq_word),
        .err_valid  (err_valid),
        .err_code   (err_code),
        .err_fid    (err_fid),
        .err_qual   (err_qual)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= msg_rd_en;
    end

    assign msg_rd_valid = rd_q;
    assign msg_rd_data  = rd_q ? '1 : '0;

    AST_WINDOW_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        msg_rd_en |=> (msg_rd_valid && msg_rd_data == 32'hFFFF_FFFF))
        else $error("window read not all ones"); // R10

endmodule

// File: tb/msi_bitmap_setter_tb_top.sv
module msi_bitmap_setter_tb_top;
    import msib_pkg::*;

    localparam int NF = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              msg_valid = 1'b0;
    logic              msg_ready;
    logic [31:0]       msg_wdata = '0;
    logic              msg_rd_en = 1'b0;
    logic              msg_rd_valid;
    logic [31:0]       msg_rd_data;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_idx = '0;
    logic              cfg_valid = 1'b0;
    logic [20:0]       cfg_fid = '0;
    logic [31:0]       cfg_ind_base = '0;
    logic [15:0]       cfg_ind_off = '0;
    logic [31:0]       cfg_sum_base = '0;
    logic [15:0]       cfg_sum_off = '0;
    logic [2:0]        cfg_isc = '0;
    logic              mem_req, mem_we, mem_lock;
    logic [31:0]       mem_addr;
    logic [7:0]        mem_wdata;
    logic              mem_rvalid;
    logic [7:0]        mem_rdata;
    logic              mem_err;
    logic              irq_valid;
    logic [31:0]       irq_word;
    logic              err_valid;
    logic [7:0]        err_code;
    logic [20:0]       err_fid;
    logic [31:0]       err_qual;

    always #5 clk = ~clk;

    msi_bitmap_setter #(.NUM_FN(NF)) dut_i (
        .clk(clk), .rst(rst),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_wdata(msg_wdata),
        .msg_rd_en(msg_rd_en), .msg_rd_valid(msg_rd_valid), .msg_rd_data(msg_rd_data),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_fid(cfg_fid),
        .cfg_ind_base(cfg_ind_base), .cfg_ind_off(cfg_ind_off),
        .cfg_sum_base(cfg_sum_base), .cfg_sum_off(cfg_sum_off), .cfg_isc(cfg_isc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_err(mem_err),
        .irq_valid(irq_valid), .irq_word(irq_word),
        .err_valid(err_valid), .err_code(err_code), .err_fid(err_fid), .err_qual(err_qual)
    );

    // byte memory model, one-cycle read latency, with an operation log
    logic [7:0] mem [0:4095];
    int fault_addr = -1;
    int op_n;
    int op_we   [0:1023];
    int op_addr [0:1023];
    int op_lock [0:1023];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
            mem_rvalid <= 1'b0;
            mem_rdata  <= 8'h00;
            mem_err    <= 1'b0;
            op_n       <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            mem_err    <= 1'b0;
            if (mem_req) begin
                op_we[op_n % 1024]   <= int'(mem_we);
                op_addr[op_n % 1024] <= int'(mem_addr);
                op_lock[op_n % 1024] <= int'(mem_lock);
                op_n <= op_n + 1;
                if (mem_we) begin
                    mem[mem_addr[11:0]] <= mem_wdata;
                end else begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[mem_addr[11:0]];
                    mem_err    <= (int'(mem_addr) == fault_addr);
                end
            end
        end
    end

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] exp_mem [0:4095];
    bit          t_vld [NF];
    int unsigned t_fid [NF];
    int unsigned t_ib [NF], t_io [NF], t_sb [NF], t_so [NF], t_isc [NF];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_slot(input int idx, input bit v, input int unsigned fid,
                            input int unsigned ib, input int unsigned io,
                            input int unsigned sb, input int unsigned so,
                            input int unsigned isc);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = v; cfg_fid = 21'(fid);
        cfg_ind_base = ib; cfg_ind_off = 16'(io); cfg_sum_base = sb;
        cfg_sum_off = 16'(so); cfg_isc = 3'(isc);
        @(negedge clk);
        cfg_we = 1'b0;
        t_vld[idx] = v; t_fid[idx] = fid & 32'h1F_FFFF; t_ib[idx] = ib; t_io[idx] = io;
        t_sb[idx] = sb; t_so[idx] = so; t_isc[idx] = isc & 7;
    endtask

    // send one message, compute expectations from the requirements, compare
    task automatic send(input logic [31:0] d);
        int unsigned fid, vec, ia, sa, im, sm, nb;
        int slot, exp_busy, busy, op0;
        bit exp_err, exp_irq, got_irq, got_err;
        int exp_code;
        logic [31:0] exp_qual, exp_word, g_word, g_qual;
        logic [20:0] exp_fid, g_fid;
        logic [7:0]  g_code, old_sum;
        fid = d >> 11;                    // R1
        vec = d & 32'h7FF;                // R1
        slot = -1;
        for (int i = NF - 1; i >= 0; i--) if (t_vld[i] && t_fid[i] == fid) slot = i; // R11
        exp_irq = 0; exp_err = 0; exp_code = 0; exp_qual = 0; exp_fid = 0; exp_word = 0;
        ia = 0; sa = 0; im = 0; sm = 0;
        if (slot < 0) begin
            exp_err = 1; exp_code = 'h10; exp_fid = 21'(fid); exp_qual = vec << 16; exp_busy = 1;
        end else begin
            nb = t_io[slot] + vec;
            ia = t_ib[slot] + nb / 8; im = 32'h80 >> (nb % 8);       // R2
            sa = t_sb[slot] + t_so[slot] / 8; sm = 32'h80 >> (t_so[slot] % 8); // R3
            if (int'(ia) == fault_addr) begin
                exp_err = 1; exp_code = 'h13; exp_busy = 3;
            end else begin
                exp_mem[ia] = exp_mem[ia] | 8'(im);
                if (int'(sa) == fault_addr) begin
                    exp_err = 1; exp_code = 'h13; exp_busy = 6;
                end else begin
                    old_sum = exp_mem[sa];
                    exp_irq = (old_sum == 8'h00);
                    exp_word = 32'h8000_0000 | (t_isc[slot] << 27);
                    exp_mem[sa] = exp_mem[sa] | 8'(sm);
                    exp_busy = 7;
                end
            end
        end
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        op0 = op_n;
        msg_valid = 1'b1; msg_wdata = d;
        @(negedge clk);
        msg_valid = 1'b0;
        busy = 0; got_irq = 0; got_err = 0; g_word = 0; g_qual = 0; g_fid = 0; g_code = 0;
        for (int k = 0; k < 50; k++) begin
            if (irq_valid) begin got_irq = 1; g_word = irq_word; end
            if (err_valid) begin got_err = 1; g_code = err_code; g_fid = err_fid; g_qual = err_qual; end
            if (msg_ready) break;
            busy++;
            @(negedge clk);
        end
        chk(busy == exp_busy, "R9 busy cycles", busy, exp_busy);
        chk(got_irq == exp_irq, "R6 interrupt presence", got_irq, exp_irq);
        if (exp_irq && got_irq) chk(g_word == exp_word, "R6 interrupt word", g_word, exp_word);
        chk(got_err == exp_err, "R7/R8 error presence", got_err, exp_err);
        if (exp_err && got_err) begin
            chk(g_code == 8'(exp_code), exp_code == 'h10 ? "R7 code" : "R8 code", g_code, exp_code);
            chk(g_fid == exp_fid, exp_code == 'h10 ? "R7 fid" : "R8 fid", g_fid, exp_fid);
            chk(g_qual == exp_qual, exp_code == 'h10 ? "R7 qualifier" : "R8 qualifier", g_qual, exp_qual);
        end
        if (slot < 0) chk(op_n == op0, "R7 no memory access", op_n - op0, 0);
        if (slot >= 0) begin
            chk(mem[ia[11:0]] == exp_mem[ia], "R2 indicator byte", mem[ia[11:0]], exp_mem[ia]);
            chk(mem[sa[11:0]] == exp_mem[sa], "R3 summary byte", mem[sa[11:0]], exp_mem[sa]);
        end
        if (exp_busy == 7) begin
            chk(op_n - op0 == 4, "R5 op count", op_n - op0, 4);
            chk(op_we[op0%1024] == 0 && op_addr[op0%1024] == int'(ia), "R5 op1 ind read", op_addr[op0%1024], ia);
            chk(op_we[(op0+1)%1024] == 1 && op_addr[(op0+1)%1024] == int'(ia), "R4 op2 ind write", op_addr[(op0+1)%1024], ia);
            chk(op_we[(op0+2)%1024] == 0 && op_addr[(op0+2)%1024] == int'(sa), "R5 op3 sum read", op_addr[(op0+2)%1024], sa);
            chk(op_we[(op0+3)%1024] == 1 && op_addr[(op0+3)%1024] == int'(sa), "R5 op4 sum write", op_addr[(op0+3)%1024], sa);
            chk(op_lock[op0%1024] == 1 && op_lock[(op0+1)%1024] == 1 &&
                op_lock[(op0+2)%1024] == 1 && op_lock[(op0+3)%1024] == 1, "R4 lock held", 0, 1);
        end
        if (exp_busy == 3) chk(op_n - op0 == 1, "R8 no access after fault", op_n - op0, 1);
        if (exp_busy == 6) chk(op_n - op0 == 3, "R8 no summary write", op_n - op0, 3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 4096; i++) exp_mem[i] = 8'h00;
        for (int i = 0; i < NF; i++) t_vld[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(msg_ready == 1'b1, "R12 ready after reset", msg_ready, 1);
        chk(!mem_req && !irq_valid && !err_valid, "R12 idle outputs", {mem_req, irq_valid, err_valid}, 0);
        send(32'h0000_0805); // R12 empty table: fid 1 unknown

        // R10 window read
        @(negedge clk); msg_rd_en = 1'b1;
        @(negedge clk); msg_rd_en = 1'b0;
        chk(msg_rd_valid && msg_rd_data == 32'hFFFF_FFFF, "R10 window read", msg_rd_data, 32'hFFFF_FFFF);
        @(negedge clk);
        chk(!msg_rd_valid, "R10 single answer", msg_rd_valid, 0);

        // directed: MSB-first mask and byte crossing
        cfg_slot(0, 1, 21'h1F_FFFF, 100, 7, 3000, 0, 5);
        send({21'h1F_FFFF, 11'd0});     // R2 bit 7 -> mask 01, R6 first summary
        send({21'h1F_FFFF, 11'd1});     // R2 crosses to next byte, R6 no irq
        send({21'h1F_FFFF, 11'd2047});  // R1 max vector
        // duplicate identifiers: lower slot wins
        cfg_slot(5, 1, 21'h00_0123, 400, 3, 3010, 9, 2);
        cfg_slot(2, 1, 21'h00_0123, 600, 0, 3020, 15, 6);
        send({21'h00_0123, 11'd4});     // R11 slot 2 wins
        cfg_slot(2, 0, 21'h00_0123, 600, 0, 3020, 15, 6);
        send({21'h00_0123, 11'd4});     // R11 slot 5 now
        cfg_slot(5, 0, 21'h00_0123, 400, 3, 3010, 9, 2);
        send({21'h00_0123, 11'd4});     // R11 invalidated -> R7
        // faults
        cfg_slot(3, 1, 21'h00_0777, 800, 0, 3040, 0, 1);
        fault_addr = 800;
        send({21'h00_0777, 11'd3});     // R8 indicator fault
        fault_addr = 3040;
        send({21'h00_0777, 11'd9});     // R8 summary fault
        fault_addr = -1;
        send({21'h00_0777, 11'd9});     // completes, R6 irq with isc 1

        // constrained random
        for (int i = 0; i < NF; i++)
            cfg_slot(i, 1, $urandom & 32'h1F_FFFF, 64 + ($urandom % 1500), $urandom % 300,
                     2048 + ($urandom % 1000), $urandom % 64, $urandom % 8);
        for (int n = 0; n < 60; n++) begin
            int unsigned f;
            f = ($urandom % 4 != 0) ? t_fid[$urandom % NF] : ($urandom & 32'h1F_FFFF);
            send({f[20:0], 11'($urandom)});
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule